// File: doc/BRIEF.md
# Dual-Issue Pipe Steering

This block sits between a two-wide issue stage and four dispatch stages: a complex-integer stage, a simple-integer stage, a load/store stage and a floating-point stage. Every cycle it looks at up to two issued instructions. Slot 0 holds the older instruction and slot 1 the younger. Each instruction carries a 4-bit class tag. The block also sees one busy flag per dispatch stage. From these it decides which slots are granted and which dispatch stages each granted slot occupies. The decision is combinational, so the issue stage can hold any slot that is not granted and offer it again in the next cycle.

Simple integer work can be placed on either integer pipe. Multiply, divide, trap, branch and special-register moves are bound to the complex pipe. Memory classes go to the load/store pipe, and floating-point classes go to the floating-point pipe. Two classes claim several stages at once. The reserve/conditional class must come from slot 0 and uses both the complex and load/store stages. The instruction-sync class uses the complex, load/store and floating-point stages together. The younger slot is never granted ahead of the older one.

Top module: `dual_steer`

## Requirements
- R1: Stage bits in sel0_o/sel1_o and busy_i are: bit0 complex-integer, bit1 simple-integer, bit2 load/store, bit3 floating-point. A valid slot 0 with a fixed class is granted exactly when none of its stages is busy, and sel0_o then equals its stage set. Class codes 1 (multiply), 2 (divide) and 3 (branch/SPR/trap) map to 4'b0001. Codes 4 (load), 5 (store) and 7 (memory sync) map to 4'b0100.
- R2: A slot 0 of class 0 (simple integer) takes the complex stage when it is free, unless slot 1 is valid with a fixed class that needs the complex stage and the simple stage is free. In that case, or when the complex stage is busy, it takes the simple stage. It stalls when both are busy.
- R3: Slot 1 is granted only in a cycle where slot 0 is granted.
- R4: A stage is never selected by both slots, and a busy stage is never selected.
- R5: Class 6 (reserve/conditional) occupies 4'b0101 from slot 0 and is never granted from slot 1.
- R6: Class 8 (instruction sync) occupies 4'b1101 and is granted only when all three of those stages are free.
- R7: A slot 1 of class 0 takes the complex stage if slot 0 did not take it and it is not busy. Otherwise it takes the simple stage if that stage is available. If neither is available, it stalls.
- R8: Class codes 11 to 15 are never granted in either slot.
- R9: An invalid slot is not granted, and its select is 4'b0000. The select of any slot that is not granted is 4'b0000.
- R10: Classes 9 (floating-point) and 10 (floating-point divide) occupy 4'b1000 only. Two such classes offered together issue one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock (used by the embedded checks) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vld_i | input | 2 | Slot valid, bit n for slot n |
| cls0_i | input | 4 | Class tag of slot 0 (older) |
| cls1_i | input | 4 | Class tag of slot 1 (younger) |
| busy_i | input | 4 | Dispatch stage busy flags |
| gnt_o | output | 2 | Slot grant, bit n for slot n |
| sel0_o | output | 4 | Stages occupied by slot 0 |
| sel1_o | output | 4 | Stages occupied by slot 1 |

## Verification
Directed pairs pit the two slots against each other on the complex pipe: flexible against flexible, flexible against bound, and bound against flexible. Together they separate the slot 0 yield rule from the slot 1 fallback. Other directed cases stall slot 0 while slot 1 has a free pipe, which exposes any break in program order. They also offer the multi-stage classes in each slot, with one of their stages busy, and offer unassigned codes. A long run of random class pairs under random busy masks, from a fixed seed, is compared with a bench model. This catches wrong stage masks, overlapping selects and grants onto busy stages across every pairing of classes.

// File: rtl/dual_steer_pkg.sv
package dual_steer_pkg;
  parameter int CLS_W  = 4;
  parameter int PIPE_N = 4;

  localparam int P_CX = 0;
  localparam int P_SX = 1;
  localparam int P_LS = 2;
  localparam int P_FP = 3;

  typedef logic [PIPE_N-1:0] pmask_t;

  localparam pmask_t M_CX = pmask_t'(1) << P_CX;
  localparam pmask_t M_SX = pmask_t'(1) << P_SX;
  localparam pmask_t M_LS = pmask_t'(1) << P_LS;
  localparam pmask_t M_FP = pmask_t'(1) << P_FP;

  typedef enum logic [CLS_W-1:0] {
    C_SIMPLE = 4'd0,
    C_MUL    = 4'd1,
    C_DIV    = 4'd2,
    C_BRSPR  = 4'd3,
    C_LOAD   = 4'd4,
    C_STORE  = 4'd5,
    C_RESV   = 4'd6,
    C_SYNC   = 4'd7,
    C_ISYNC  = 4'd8,
    C_FP     = 4'd9,
    C_FDIV   = 4'd10
  } cls_e;
endpackage

// File: rtl/steer_decode.sv
module steer_decode
  import dual_steer_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic [CLS_W-1:0] cls_i,
  output pmask_t           need_o,
  output logic             flex_o,
  output logic             ok_o
);
  always_comb begin
    need_o = '0;
    flex_o = 1'b0;
    ok_o   = 1'b1;
    case (cls_i)
      C_SIMPLE:              flex_o = 1'b1;
      C_MUL, C_DIV, C_BRSPR: need_o = M_CX;
      C_LOAD, C_STORE, C_SYNC: need_o = M_LS;
      C_RESV: begin
        need_o = M_CX | M_LS;
        ok_o   = (SLOT == 0);
      end
      C_ISYNC:               need_o = M_CX | M_LS | M_FP;
      C_FP, C_FDIV:          need_o = M_FP;
      default:               ok_o   = 1'b0;
    endcase
  end
endmodule

// File: rtl/steer_pick.sv
module steer_pick
  import dual_steer_pkg::*;
(
  input  logic [1:0] vld_i,
  input  pmask_t     need0_i,
  input  pmask_t     need1_i,
  input  logic       flex0_i,
  input  logic       flex1_i,
  input  logic       ok0_i,
  input  logic       ok1_i,
  input  pmask_t     busy_i,
  output logic [1:0] gnt_o,
  output pmask_t     sel0_o,
  output pmask_t     sel1_o
);
  pmask_t free0, free1, pick0, pick1;
  logic   s1_bound_cx;

  always_comb begin
    free0       = ~busy_i;
    // younger slot is pinned to the complex pipe: let a flexible slot 0 yield
    s1_bound_cx = vld_i[1] & ok1_i & ~flex1_i & need1_i[P_CX];

    if (flex0_i) begin
      if (free0[P_CX] && !(s1_bound_cx && free0[P_SX])) pick0 = M_CX;
      else if (free0[P_SX])                             pick0 = M_SX;
      else                                              pick0 = '0;
      gnt_o[0] = vld_i[0] & ok0_i & (pick0 != '0);
    end else begin
      pick0    = need0_i;
      gnt_o[0] = vld_i[0] & ok0_i & ((need0_i & busy_i) == '0);
    end
    sel0_o = gnt_o[0] ? pick0 : '0;

    free1 = ~busy_i & ~sel0_o;
    if (flex1_i) begin
      if (free1[P_CX])      pick1 = M_CX;
      else if (free1[P_SX]) pick1 = M_SX;
      else                  pick1 = '0;
      gnt_o[1] = gnt_o[0] & vld_i[1] & ok1_i & (pick1 != '0);
    end else begin
      pick1    = need1_i;
      gnt_o[1] = gnt_o[0] & vld_i[1] & ok1_i & ((need1_i & ~free1) == '0);
    end
    sel1_o = gnt_o[1] ? pick1 : '0;
  end
endmodule

// File: rtl/dual_steer.sv
module dual_steer
  import dual_steer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       vld_i,
  input  logic [CLS_W-1:0] cls0_i,
  input  logic [CLS_W-1:0] cls1_i,
  input  logic [PIPE_N-1:0] busy_i,
  output logic [1:0]       gnt_o,
  output logic [PIPE_N-1:0] sel0_o,
  output logic [PIPE_N-1:0] sel1_o
);
  localparam int SLOTS = 2;

  logic [CLS_W-1:0] cls_a  [SLOTS];
  pmask_t           need_a [SLOTS];
  logic [SLOTS-1:0] flex_a, ok_a;

  assign cls_a[0] = cls0_i;
  assign cls_a[1] = cls1_i;

  for (genvar s = 0; s < SLOTS; s++) begin : g_dec
    steer_decode #(.SLOT(s)) u_dec (
      .cls_i  (cls_a[s]),
      .need_o (need_a[s]),
      .flex_o (flex_a[s]),
      .ok_o   (ok_a[s])
    );
  end

  steer_pick u_pick (
    .vld_i   (vld_i),
    .need0_i (need_a[0]),
    .need1_i (need_a[1]),
    .flex0_i (flex_a[0]),
    .flex1_i (flex_a[1]),
    .ok0_i   (ok_a[0]),
    .ok1_i   (ok_a[1]),
    .busy_i  (busy_i),
    .gnt_o   (gnt_o),
    .sel0_o  (sel0_o),
    .sel1_o  (sel1_o)
  );

  p_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[1] |-> gnt_o[0]) else $error("slot 1 granted past stalled slot 0");

  p_disjoint_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel0_o & sel1_o) == '0) else $error("stage selected twice");

  p_no_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sel0_o | sel1_o) & busy_i) == '0) else $error("busy stage selected");

  p_resv_slot0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i[1] && cls1_i == C_RESV) |-> !gnt_o[1]) else $error("conditional class from slot 1");

  p_isync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o[0] && cls0_i == C_ISYNC) |-> (sel0_o == (M_CX | M_LS | M_FP)))
    else $error("isync stage set");

  p_unknown_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i[0] && cls0_i > C_FDIV) |-> !gnt_o[0]) else $error("unassigned class granted");

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_o[0] |-> (sel0_o == '0 && sel1_o == '0)) else $error("select without grant");
endmodule

// File: tb/tb_dual_steer.sv
module tb_dual_steer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] vld_i = '0;
  logic [3:0] cls0_i = '0, cls1_i = '0, busy_i = '0;
  logic [1:0] gnt_o;
  logic [3:0] sel0_o, sel1_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk_i = ~clk_i;

  dual_steer dut (.*);

  function automatic logic [3:0] ref_need(input logic [3:0] c);
    case (c)
      4'd1, 4'd2, 4'd3: return 4'b0001;
      4'd4, 4'd5, 4'd7: return 4'b0100;
      4'd6:             return 4'b0101;
      4'd8:             return 4'b1101;
      4'd9, 4'd10:      return 4'b1000;
      default:          return 4'b0000;
    endcase
  endfunction

  // returns {gnt[1:0], sel0[3:0], sel1[3:0]}
  function automatic logic [9:0] ref_model(input logic [1:0] v, input logic [3:0] c0,
                                           input logic [3:0] c1, input logic [3:0] b);
    logic g0, g1;
    logic [3:0] s0, s1, av;
    logic bound1;
    g0 = 0; g1 = 0; s0 = 0; s1 = 0;
    bound1 = v[1] && c1 inside {4'd1, 4'd2, 4'd3, 4'd8};
    if (v[0]) begin
      if (c0 == 4'd0) begin
        if (!b[0] && !(bound1 && !b[1])) s0 = 4'b0001;
        else if (!b[1])                  s0 = 4'b0010;
      end else if (c0 <= 4'd10 && (ref_need(c0) & b) == 0) s0 = ref_need(c0);
      g0 = (s0 != 0);
    end
    av = ~b & ~s0;
    if (g0 && v[1]) begin
      if (c1 == 4'd0) begin
        if (av[0])      s1 = 4'b0001;
        else if (av[1]) s1 = 4'b0010;
      end else if (c1 <= 4'd10 && c1 != 4'd6 && (ref_need(c1) & ~av) == 0) s1 = ref_need(c1);
      g1 = (s1 != 0);
    end
    return {g1, g0, s0, s1};
  endfunction

  task automatic check(input string req);
    logic [9:0] exp, act;
    exp = ref_model(vld_i, cls0_i, cls1_i, busy_i);
    act = {gnt_o, sel0_o, sel1_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s v=%b c0=%0d c1=%0d busy=%b act gnt=%b s0=%b s1=%b exp gnt=%b s0=%b s1=%b",
               req, vld_i, cls0_i, cls1_i, busy_i, act[9:8], act[7:4], act[3:0],
               exp[9:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic apply(input logic [1:0] v, input logic [3:0] c0, input logic [3:0] c1,
                       input logic [3:0] b, input string req);
    @(negedge clk_i);
    vld_i = v; cls0_i = c0; cls1_i = c1; busy_i = b;
    #5 check(req);
  endtask

  task automatic expect_eq(input string req, input logic [9:0] exp);
    total++;
    if ({gnt_o, sel0_o, sel1_o} !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, {gnt_o, sel0_o, sel1_o}, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1 expect_eq("R9 reset idle", 10'b0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;

    apply(2'b11, 4'd0, 4'd0, 4'b0000, "R2 R7 flex pair");
    expect_eq("R2 R7 flex pair spread", {2'b11, 4'b0001, 4'b0010});
    apply(2'b11, 4'd0, 4'd1, 4'b0000, "R2 slot0 yields complex");
    expect_eq("R2 yield", {2'b11, 4'b0010, 4'b0001});
    apply(2'b11, 4'd2, 4'd0, 4'b0000, "R7 slot1 to simple");
    apply(2'b11, 4'd0, 4'd1, 4'b0010, "R2 simple busy keeps complex");
    apply(2'b01, 4'd0, 4'd0, 4'b0011, "R2 both int busy stall");
    apply(2'b11, 4'd4, 4'd9, 4'b0100, "R3 stalled older blocks younger");
    expect_eq("R3 order", 10'b0);
    apply(2'b11, 4'd6, 4'd0, 4'b0000, "R5 resv slot0");
    expect_eq("R5 resv mask", {2'b11, 4'b0101, 4'b0010});
    apply(2'b11, 4'd4, 4'd6, 4'b0000, "R5 resv slot1 refused");
    apply(2'b01, 4'd8, 4'd0, 4'b0000, "R6 isync");
    apply(2'b01, 4'd8, 4'd0, 4'b1000, "R6 isync partial busy");
    apply(2'b11, 4'd12, 4'd0, 4'b0000, "R8 unassigned slot0");
    apply(2'b11, 4'd1, 4'd15, 4'b0000, "R8 unassigned slot1");
    apply(2'b11, 4'd9, 4'd10, 4'b0000, "R10 fp pair serialises");
    apply(2'b11, 4'd5, 4'd7, 4'b0000, "R1 R4 two memory ops");
    apply(2'b11, 4'd3, 4'd4, 4'b0000, "R1 branch and load");
    apply(2'b10, 4'd0, 4'd9, 4'b0000, "R9 slot0 empty");
    apply(2'b00, 4'd0, 4'd0, 4'b0000, "R9 no valid");

    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a, c;
      a = 4'($urandom_range(0, 15));
      c = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) == 0) a = 4'd0;
      if ($urandom_range(0, 3) == 0) c = 4'd0;
      apply(2'($urandom_range(0, 3)), a, c, 4'($urandom_range(0, 15)), "R1 R4 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule